// File: doc/BRIEF.md
# Parallel OTN frame aligner

This block takes the 64-bit words that a deserializer delivers, one word per clock, and recovers the frame and byte boundaries of an OTU2 line signal that can sit at any bit offset across the lanes. Line bits arrive in order from bit 63 down to bit 0 of each word. The output is realigned so that every frame starts at bit 63 of an output word. A start-of-frame strobe marks that word and a status flag reports lock.

While unlocked, the block hunts in two steps. The first step looks at every bit position of a two-word window for the 16-bit boundary where the alignment byte 0xF6 is followed by 0x28. The lowest position that matches is registered as a candidate. In the next cycle a second step shifts the window by that amount and checks that the two leading pattern bytes 0xF6 0xF6 sit just ahead of the boundary. After lock, a frame counter of 2040 words predicts where the next pattern must appear. The block then checks the whole 4-byte sequence 0xF6 0xF6 0x28 0x28 once per frame at that place, using the held bit offset.

Top module: `otn_frame_aligner`

## Requirements
- R1: While reset is asserted, `in_frame`, `frame_start` and `algn_word` are all zero.
- R2: While locked, each output word equals the transmitted frame word bit for bit, with the earliest line bit in bit 63. This holds for any line bit offset from 0 to 63, and the bit offset stays fixed for as long as lock holds.
- R3: `frame_start` is high only while `in_frame` is high. It marks the output word whose bits 63:16 carry the six framing bytes F6 F6 F6 28 28 28, so the 4-byte search sequence sits at bits 55:24.
- R4: While locked, `frame_start` repeats every FRAME_WORDS (2040) words, including frames whose pattern is missing.
- R5: From the hunting state, `in_frame` rises at the second consecutive frame that shows the sequence at the same offset, and never at the first.
- R6: While hunting, a held candidate whose sequence is missing one frame later is dropped, and the count of good frames starts again from zero.
- R7: While locked, `in_frame` falls at the fifth consecutive frame whose 4-byte sequence mismatches at the predicted place. Four misses followed by a good frame keep lock.
- R8: After the line bit offset changes, the block drops lock and then locks again at the new offset, including the extreme offsets 0 and 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word | input | 64 | Unaligned word from the deserializer, earliest bit in bit 63 |
| algn_word | output | 64 | Realigned word, frame boundaries at bit 63 |
| frame_start | output | 1 | Marks the output word that carries the first framing byte |
| in_frame | output | 1 | High while the block holds frame lock |

## Verification
A wrong held bit offset or a frame counter that has drifted shows up within one frame. Every output word then differs from the transmitted frame, and the strobe lands away from the framing bytes or breaks its 2040-word period. A miss counter or good-frame counter that is off by one moves the edge of `in_frame` by a whole frame. A frame-level model in the bench predicts the lock flag mid-frame, so that fault appears at the exact frame where the count goes wrong. A search that picks the wrong candidate delays relock, and this is caught after an offset change when lock does not return.

// File: rtl/ofa_pkg.sv
package ofa_pkg;
  typedef enum logic {MODE_HUNT = 1'b0, MODE_LOCK = 1'b1} mode_e;

  localparam logic [7:0]  OA_FIRST  = 8'hF6;
  localparam logic [7:0]  OA_SECOND = 8'h28;
  // boundary searched in step one, leading bytes checked in step two
  localparam logic [15:0] EDGE_PAT  = {OA_FIRST, OA_SECOND};
  localparam logic [15:0] LEAD_PAT  = {OA_FIRST, OA_FIRST};
  localparam logic [31:0] FULL_PAT  = {OA_FIRST, OA_FIRST, OA_SECOND, OA_SECOND};
endpackage

// File: rtl/ofa_word_pipe.sv
module ofa_word_pipe #(
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   din,
  output logic [2*DW-1:0] win_now,
  output logic [2*DW-1:0] win_old
);
  logic [DW-1:0] d0_q, d1_q, d2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d0_q <= '0;
      d1_q <= '0;
      d2_q <= '0;
    end else begin
      d0_q <= din;
      d1_q <= d0_q;
      d2_q <= d1_q;
    end
  end

  // older word on top: earliest bit at the MSB of each window
  assign win_now = {d1_q, d0_q};
  assign win_old = {d2_q, d1_q};
endmodule

// File: rtl/ofa_edge_search.sv
module ofa_edge_search
  import ofa_pkg::*;
#(
  parameter int DW = 64,
  localparam int OW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] win,
  output logic            hit_q,
  output logic [OW-1:0]   off_q
);
  logic [DW-1:0] hit_vec;
  logic          found;
  logic [OW-1:0] off_n;

  // boundary bytes land on aligned bits 47:32 when slice starts at bit g
  for (genvar g = 0; g < DW; g++) begin : g_cmp
    assign hit_vec[g] = (win[2*DW-17-g -: 16] == EDGE_PAT);
  end

  always_comb begin
    found = 1'b0;
    off_n = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        found = 1'b1;
        off_n = OW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      off_q <= '0;
    end else begin
      hit_q <= found;
      off_q <= off_n;
    end
  end

  // R5: a registered candidate always came from a matching boundary
  assert_cand_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(|hit_vec));
endmodule

// File: rtl/ofa_shifter.sv
module ofa_shifter #(
  parameter int DW = 64,
  localparam int OW = $clog2(DW)
) (
  input  logic [2*DW-1:0] win,
  input  logic [OW-1:0]   sh,
  output logic [DW-1:0]   dout
);
  logic [2*DW-1:0] shifted;

  assign shifted = win << sh;
  assign dout    = shifted[2*DW-1 -: DW];
endmodule

// File: rtl/ofa_sync_ctrl.sv
module ofa_sync_ctrl
  import ofa_pkg::*;
#(
  parameter int DW          = 64,
  parameter int FRAME_WORDS = 2040,
  parameter int LOSS_FRAMES = 5,
  parameter int GAIN_FRAMES = 2,
  localparam int OW   = $clog2(DW),
  localparam int FC_W = $clog2(FRAME_WORDS),
  localparam int LW   = $clog2(LOSS_FRAMES + 1),
  localparam int GW   = $clog2(GAIN_FRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cand_hit,
  input  logic [OW-1:0] cand_off,
  input  logic          pat_ok,
  output logic [OW-1:0] lock_off,
  output mode_e         mode,
  output logic          at_fas
);
  mode_e           mode_q, mode_n;
  logic [FC_W-1:0] fc_q, fc_n;
  logic            have_q, have_n;
  logic [GW-1:0]   good_q, good_n;
  logic [LW-1:0]   miss_q, miss_n;
  logic [OW-1:0]   off_q, off_n;

  assign at_fas   = (fc_q == '0);
  assign lock_off = off_q;
  assign mode     = mode_q;

  // next state; GAIN_FRAMES is taken as at least 2
  always_comb begin
    mode_n = mode_q;
    have_n = have_q;
    good_n = good_q;
    miss_n = miss_q;
    off_n  = off_q;
    fc_n   = (fc_q == FC_W'(FRAME_WORDS - 1)) ? '0 : fc_q + FC_W'(1);
    case (mode_q)
      MODE_HUNT: begin
        if (have_q && at_fas) begin
          if (pat_ok) begin
            if (int'(good_q) + 1 >= GAIN_FRAMES) begin
              mode_n = MODE_LOCK;
              good_n = '0;
              miss_n = '0;
            end else begin
              good_n = good_q + GW'(1);
            end
          end else begin
            have_n = 1'b0;
            good_n = '0;
          end
        end else if (!have_q && cand_hit) begin
          have_n = 1'b1;
          off_n  = cand_off;
          good_n = GW'(1);
          fc_n   = FC_W'(1);
        end
      end
      default: begin
        if (at_fas) begin
          if (pat_ok) begin
            miss_n = '0;
          end else if (int'(miss_q) + 1 >= LOSS_FRAMES) begin
            mode_n = MODE_HUNT;
            have_n = 1'b0;
            good_n = '0;
            miss_n = '0;
          end else begin
            miss_n = miss_q + LW'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_HUNT;
      fc_q   <= '0;
      have_q <= 1'b0;
      good_q <= '0;
      miss_q <= '0;
      off_q  <= '0;
    end else begin
      mode_q <= mode_n;
      fc_q   <= fc_n;
      have_q <= have_n;
      good_q <= good_n;
      miss_q <= miss_n;
      off_q  <= off_n;
    end
  end

  assert_fc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fc_q < FC_W'(FRAME_WORDS));
  assert_flywheel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LOCK && fc_q == FC_W'(FRAME_WORDS - 1)) |=> (fc_q == '0));
  assert_lock_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q == MODE_LOCK) |-> $past(at_fas && pat_ok && have_q));
  assert_lock_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q == MODE_LOCK) |-> $past(at_fas && !pat_ok && miss_q == LW'(LOSS_FRAMES - 1)));
  assert_miss_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q < LW'(LOSS_FRAMES));
  assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LOCK && $past(mode_q == MODE_LOCK)) |-> $stable(off_q));
  assert_drop_cand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HUNT && have_q && at_fas && !pat_ok) |=> (!have_q && good_q == '0));
endmodule

// File: rtl/otn_frame_aligner.sv
module otn_frame_aligner
  import ofa_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int FRAME_WORDS = 2040,
  parameter int LOSS_FRAMES = 5,
  parameter int GAIN_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_word,
  output logic [DATA_W-1:0] algn_word,
  output logic              frame_start,
  output logic              in_frame
);
  localparam int OW = $clog2(DATA_W);

  logic [2*DATA_W-1:0] win_now, win_old;
  logic                hit_q;
  logic [OW-1:0]       hit_off, lock_off;
  logic [DATA_W-1:0]   lead_word, main_word;
  logic                cand_hit, pat_ok, at_fas;
  mode_e               mode;
  logic [DATA_W-1:0]   algn_q;
  logic                sof_q, inf_q;

  ofa_word_pipe #(.DW(DATA_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .din(rx_word),
    .win_now(win_now), .win_old(win_old));

  ofa_edge_search #(.DW(DATA_W)) u_search (
    .clk(clk), .rst_n(rst_n), .win(win_now),
    .hit_q(hit_q), .off_q(hit_off));

  // step two: leading bytes under the candidate shift
  ofa_shifter #(.DW(DATA_W)) u_lead_sh (
    .win(win_old), .sh(hit_off), .dout(lead_word));

  // data path and per-frame confirmation under the held shift
  ofa_shifter #(.DW(DATA_W)) u_main_sh (
    .win(win_old), .sh(lock_off), .dout(main_word));

  assign cand_hit = hit_q && (lead_word[DATA_W-9 -: 16] == LEAD_PAT);
  assign pat_ok   = (main_word[DATA_W-9 -: 32] == FULL_PAT);

  ofa_sync_ctrl #(
    .DW(DATA_W), .FRAME_WORDS(FRAME_WORDS),
    .LOSS_FRAMES(LOSS_FRAMES), .GAIN_FRAMES(GAIN_FRAMES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cand_hit(cand_hit), .cand_off(hit_off),
    .pat_ok(pat_ok), .lock_off(lock_off), .mode(mode), .at_fas(at_fas));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      algn_q <= '0;
      sof_q  <= 1'b0;
      inf_q  <= 1'b0;
    end else begin
      algn_q <= main_word;
      sof_q  <= (mode == MODE_LOCK) && at_fas;
      inf_q  <= (mode == MODE_LOCK);
    end
  end

  assign algn_word   = algn_q;
  assign frame_start = sof_q;
  assign in_frame    = inf_q;

  assert_sof_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> in_frame);
  assert_sof_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(at_fas));
endmodule

// File: tb/tb_otn_frame_aligner.sv
`timescale 1ns/1ps
module tb_otn_frame_aligner;
  localparam int CLK_P = 6;
  localparam int FW    = 2040;
  localparam logic [63:0] PAY_MASK = 64'h0F0F0F0F0F0F0F0F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] rx_word;
  logic [63:0] algn_word;
  logic        frame_start, in_frame;

  otn_frame_aligner dut (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word),
    .algn_word(algn_word), .frame_start(frame_start), .in_frame(in_frame));

  always #(CLK_P/2) clk = ~clk;

  int          n_cmp = 0, n_bad = 0;
  int          gidx = 0, boff = 0;
  logic [63:0] salt;
  logic        corrupt_map [0:63];
  string       ph_tag = "R5";
  bit          model_on = 1'b1, m_lock = 1'b0;
  int          m_good = 0, m_miss = 0;
  bit          chk_en = 1'b1, trk = 1'b0, wait_drop = 1'b0;
  int          per = 0, exp_g = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (word %0d)", tag, act, exp, gidx);
    end
  endtask

  function automatic logic [63:0] mix(input int p);
    logic [63:0] x;
    x = (64'(p) + 64'd1) * 64'h9E3779B97F4A7C15 ^ salt;
    x = x ^ (x >> 31);
    x = x * 64'hBF58476D1CE4E5B9;
    x = x ^ (x >> 29);
    return x & PAY_MASK;
  endfunction

  function automatic logic [63:0] gen(input int g);
    int f, p;
    logic [63:0] h;
    if (g < 0) return 64'd0;
    f = g / FW;
    p = g % FW;
    h = mix(p);
    if (p == 0)
      return {24'hF6F6F6, (f < 64 && corrupt_map[f]) ? 8'h00 : 8'h28, 16'h2828, h[15:0]};
    return h;
  endfunction

  function automatic logic [63:0] line_word(input int g);
    logic [127:0] t;
    t = {gen(g - 1), gen(g)} >> boff;
    return t[63:0];
  endfunction

  task automatic monitor();
    if (frame_start && !in_frame)
      chk(1'b0, "R3 strobe while unlocked", 64'(frame_start), 64'd0);
    if (!in_frame) trk = 1'b0;
    if (wait_drop && !in_frame) wait_drop = 1'b0;
    if (frame_start && !wait_drop) begin
      chk_en = 1'b1;
      if (trk) chk(per == FW, "R4 strobe period", 64'(per), 64'(FW));
      trk   = 1'b1;
      per   = 0;
      exp_g = (gidx / FW) * FW;
      chk(algn_word[63:16] == gen(exp_g) >> 16, "R3 framing bytes at strobe",
          algn_word, gen(exp_g));
    end
    if (trk && chk_en) begin
      chk(algn_word == gen(exp_g), "R2 aligned data", algn_word, gen(exp_g));
      exp_g++;
      per++;
    end
  endtask

  task automatic frame_check(input int f);
    bit good;
    good = !corrupt_map[f];
    if (!m_lock) begin
      if (good) begin
        m_good++;
        if (m_good >= 2) begin m_lock = 1'b1; m_miss = 0; m_good = 0; end
      end else m_good = 0;
    end else begin
      if (good) m_miss = 0;
      else begin
        m_miss++;
        if (m_miss >= 5) begin m_lock = 1'b0; m_miss = 0; m_good = 0; end
      end
    end
    chk(in_frame == m_lock, ph_tag, 64'(in_frame), 64'(m_lock));
  endtask

  task automatic step();
    @(negedge clk);
    monitor();
    rx_word = line_word(gidx);
    gidx++;
    if (model_on && (gidx % FW) == FW / 2) frame_check((gidx - 1) / FW);
  endtask

  task automatic run_frames(input int n);
    repeat (n * FW) step();
  endtask

  task automatic change_offset(input int nb);
    boff      = nb;
    model_on  = 1'b0;
    chk_en    = 1'b0;
    trk       = 1'b0;
    wait_drop = 1'b1;
    run_frames(10);
    chk(chk_en && in_frame, "R8 relock after offset change", 64'(in_frame), 64'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    salt = {$urandom, $urandom};
    boff = 1 + int'($urandom % 62);
    for (int i = 0; i < 64; i++) corrupt_map[i] = 1'b0;
    for (int i = 4; i <= 7; i++) corrupt_map[i] = 1'b1;
    for (int i = 10; i <= 14; i++) corrupt_map[i] = 1'b1;
    for (int i = 20; i <= 24; i++) corrupt_map[i] = 1'b1;
    corrupt_map[26] = 1'b1;

    rst_n   = 1'b0;
    rx_word = 64'd0;
    repeat (4) begin
      @(negedge clk);
      chk(in_frame == 1'b0 && frame_start == 1'b0, "R1 flags in reset",
          {62'd0, in_frame, frame_start}, 64'd0);
      chk(algn_word == 64'd0, "R1 data in reset", algn_word, 64'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    ph_tag = "R5 initial lock";      run_frames(4);
    ph_tag = "R7 four misses";       run_frames(6);
    ph_tag = "R7 five misses";       run_frames(10);
    ph_tag = "R6 broken confirmation"; run_frames(10);
    change_offset(0);
    change_offset(63);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule